// File: doc/BRIEF.md
# Multi-Region Chip Select Decoder

The decoder looks at every external bus access and decides which of seven programmable regions, if any, should receive a select strobe. Each region is described by a base address, an address mask, five access-class block bits, a DMA address-mode bit, a valid bit and a control word. The control word carries the wait-state count, auto-acknowledge enable, port size, byte-enable mode and the read/write burst enables. When a region is selected, these values are driven out beside the select lines so that the bus sequencer can shape the cycle.

Region 0 is the boot region. From reset it claims every access, whatever its address and class, so that a boot ROM can be fetched before software has programmed anything. Its control word comes out of reset with the largest wait-state count and auto-acknowledge on. Its port size is taken from two boot-strap inputs. Once software sets its valid bit, region 0 decodes like the other regions. Software programs all regions through a simple register write/read port.

Top module: `csel_decoder`

## Requirements
- R1: A valid region matches when the upper 16 address bits equal its base bits at every position where its address mask bit is 0. A mask bit of 1 makes that position don't-care.
- R2: Mask register bits [5:1] block access classes 0 to 4, where acc_type 0 = CPU space/interrupt acknowledge, 1 = supervisor code, 2 = supervisor data, 3 = user code and 4 = user data. A blocked class leaves every select high. The reserved acc_type codes 5 to 7 never select a programmed region.
- R3: When acc_dma is 1 and the region's address-mode bit (mask register bit 8) is 0, the block bits for classes 1 to 4 are ignored. The class 0 block bit still applies.
- R4: Regions 1 to 6 never assert a select while their valid bit (mask register bit 0) is 0. Reset clears every valid bit.
- R5: While region 0's valid bit is 0, region 0 is selected for every access, regardless of address, class or DMA flag.
- R6: After reset, region 0's control word reads wait states 15, auto-acknowledge 1, and a port size equal to boot_ps.
- R7: When several regions hit, only the lowest-numbered one asserts. At most one cs_n bit is low at any time.
- R8: The attribute outputs carry the selected region's control fields. They are all zero when no region is selected.
- R9: The register map uses byte offsets, with region n at base 0x80+12n, mask 0x84+12n and control 0x8A+12n. The base register holds the base in bits [31:16]. The mask register holds the mask in [31:16], the address mode in [8], the block bits in [5:1] and valid in [0]. The control register holds wait states in [3:0], auto-acknowledge in [4], port size in [6:5] (00 = 32-bit, 01 = 8-bit, 1x = 16-bit), byte-enable mode in [7], read burst in [8] and write burst in [9]. Reads return the same layout, and unmapped offsets read 0.
- R10: The select and attribute outputs are registered. They reflect the access inputs one clock edge after those inputs are presented. While reset is held, all selects are high and all attributes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_ps | input | 2 | Boot-strap port size for region 0 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| acc_addr | input | 32 | Access address |
| acc_type | input | 3 | Access class code |
| acc_dma | input | 1 | Access comes from DMA |
| cs_n | output | 7 | Active-low region selects |
| sel_ws | output | 4 | Selected region wait states |
| sel_aa | output | 1 | Selected region auto-acknowledge |
| sel_ps | output | 2 | Selected region port size |
| sel_bem | output | 1 | Selected region byte-enable mode |
| sel_bstr | output | 1 | Selected region read burst enable |
| sel_bstw | output | 1 | Selected region write burst enable |

## Verification
A register write takes effect at the clock edge that samples it, and reg_rdata follows reg_addr with no edge in between. The bench therefore drives writes and reads on the falling edge and samples reads 1 ns later. An access driven on a falling edge produces its select and attributes at the next rising edge. Every decode check samples 1 ns after that edge. One check also samples just before the edge and confirms that the previous result is still held. The class/DMA/valid/window sweep rewrites the mask register before each group, so each decode sees settled programming.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;

  localparam int unsigned NUM_CLASSES = 5;

  typedef enum logic [2:0] {
    ACC_CPU   = 3'd0,
    ACC_SCODE = 3'd1,
    ACC_SDATA = 3'd2,
    ACC_UCODE = 3'd3,
    ACC_UDATA = 3'd4
  } acc_kind_e;

  typedef struct packed {
    logic       bstw;
    logic       bstr;
    logic       bem;
    logic [1:0] ps;
    logic       aa;
    logic [3:0] ws;
  } chan_attr_t;

  localparam int unsigned ATTR_W = $bits(chan_attr_t);

endpackage

// File: rtl/csel_chan_regs.sv
`timescale 1ns/1ps
module csel_chan_regs
  import csel_pkg::*;
#(
  parameter bit          IS_BOOT = 1'b0,
  parameter int unsigned CMP_W   = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_ps,
  input  logic              wr_base,
  input  logic              wr_mask,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [CMP_W-1:0]  base_o,
  output logic [CMP_W-1:0]  amask_o,
  output logic [NUM_CLASSES-1:0] tmask_o,
  output logic              amode_o,
  output logic              valid_o,
  output chan_attr_t        attr_o,
  output logic [DATA_W-1:0] rd_base,
  output logic [DATA_W-1:0] rd_mask,
  output logic [DATA_W-1:0] rd_ctrl
);

  localparam int unsigned LOW_W = DATA_W - CMP_W;
  localparam int unsigned PAD_W = LOW_W - 9;

  logic [CMP_W-1:0]       base_q,  base_d;
  logic [CMP_W-1:0]       amask_q, amask_d;
  logic [NUM_CLASSES-1:0] tmask_q, tmask_d;
  logic                   amode_q, amode_d;
  logic                   valid_q, valid_d;
  chan_attr_t             ctrl_d;
  chan_attr_t             ctrl_eff;
  logic                   unused_wdata;

  assign unused_wdata = ^wdata;

  // next-state values for the programmable fields
  always_comb begin
    base_d  = wdata[DATA_W-1 -: CMP_W];
    amask_d = wdata[DATA_W-1 -: CMP_W];
    amode_d = wdata[8];
    tmask_d = wdata[5:1];
    valid_d = wdata[0];
    ctrl_d  = chan_attr_t'(wdata[ATTR_W-1:0]);
  end

  // window and class fields: no reset, loaded by explicit enable
  always_ff @(posedge clk) begin
    if (wr_base) base_q <= base_d;
  end

  always_ff @(posedge clk) begin
    if (wr_mask) begin
      amask_q <= amask_d;
      amode_q <= amode_d;
      tmask_q <= tmask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= 1'b0;
    else if (wr_mask) valid_q <= valid_d;
  end

  generate
    if (IS_BOOT) begin : g_boot
      chan_attr_t ctrl_q;
      logic       strap_pend_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctrl_q       <= '{bstw: 1'b0, bstr: 1'b0, bem: 1'b0, ps: 2'b00,
                            aa: 1'b1, ws: 4'hF};
          strap_pend_q <= 1'b1;
        end else if (wr_ctrl) begin
          ctrl_q       <= ctrl_d;
          strap_pend_q <= 1'b0;
        end else if (strap_pend_q) begin
          ctrl_q.ps    <= boot_ps;
          strap_pend_q <= 1'b0;
        end
      end

      always_comb begin
        ctrl_eff = ctrl_q;
        if (strap_pend_q) ctrl_eff.ps = boot_ps;
      end

      // R6
      boot_reset_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (attr_o.ws == 4'hF && attr_o.aa && attr_o.ps == boot_ps));
    end else begin : g_prog
      chan_attr_t ctrl_q;
      logic       unused_strap;

      assign unused_strap = ^boot_ps;

      always_ff @(posedge clk) begin
        if (wr_ctrl) ctrl_q <= ctrl_d;
      end

      assign ctrl_eff = ctrl_q;
    end
  endgenerate

  assign base_o  = base_q;
  assign amask_o = amask_q;
  assign tmask_o = tmask_q;
  assign amode_o = amode_q;
  assign valid_o = valid_q;
  assign attr_o  = ctrl_eff;

  assign rd_base = {base_q, {LOW_W{1'b0}}};
  assign rd_mask = {amask_q, {PAD_W{1'b0}}, amode_q, 2'b00, tmask_q, valid_q};
  assign rd_ctrl = {{(DATA_W-ATTR_W){1'b0}}, ctrl_eff};

endmodule

// File: rtl/csel_match.sv
`timescale 1ns/1ps
module csel_match
  import csel_pkg::*;
#(
  parameter int unsigned CMP_W = 16
) (
  input  logic [CMP_W-1:0]       addr_hi,
  input  logic [2:0]             acc_type,
  input  logic                   acc_dma,
  input  logic [CMP_W-1:0]       base,
  input  logic [CMP_W-1:0]       amask,
  input  logic [NUM_CLASSES-1:0] tmask,
  input  logic                   amode,
  input  logic                   valid,
  input  logic                   global_sel,
  output logic                   hit
);

  logic window_ok;
  logic class_blocked;
  logic dma_bypass;

  assign window_ok  = (((addr_hi ^ base) & ~amask) == '0);
  assign dma_bypass = acc_dma & ~amode;

  always_comb begin
    unique case (acc_type)
      ACC_CPU:   class_blocked = tmask[0];
      ACC_SCODE: class_blocked = tmask[1] & ~dma_bypass;
      ACC_SDATA: class_blocked = tmask[2] & ~dma_bypass;
      ACC_UCODE: class_blocked = tmask[3] & ~dma_bypass;
      ACC_UDATA: class_blocked = tmask[4] & ~dma_bypass;
      default:   class_blocked = 1'b1;
    endcase
  end

  assign hit = global_sel | (valid & window_ok & ~class_blocked);

endmodule

// File: rtl/csel_select.sv
`timescale 1ns/1ps
module csel_select
  import csel_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       hit,
  input  chan_attr_t [NUM_CH-1:0] attrs,
  output logic [NUM_CH-1:0]       cs_n,
  output chan_attr_t              attr_q
);

  logic [NUM_CH-1:0] cs_n_d, cs_n_q;
  chan_attr_t        attr_d, attr_r;

  // lowest index wins: scan high to low, last hit overrides
  always_comb begin
    cs_n_d = '1;
    attr_d = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (hit[c]) begin
        cs_n_d    = '1;
        cs_n_d[c] = 1'b0;
        attr_d    = attrs[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= '1;
      attr_r <= '0;
    end else begin
      cs_n_q <= cs_n_d;
      attr_r <= attr_d;
    end
  end

  assign cs_n   = cs_n_q;
  assign attr_q = attr_r;

  // R7
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_q));

  // R8
  idle_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n_q) |-> (attr_r == '0));

endmodule

// File: rtl/csel_decoder.sv
`timescale 1ns/1ps
module csel_decoder
  import csel_pkg::*;
#(
  parameter int unsigned NUM_CH    = 7,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CMP_W     = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_AW    = 8,
  parameter int unsigned MAP_ORG   = 'h80,
  parameter int unsigned MAP_STEP  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_ps,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_type,
  input  logic              acc_dma,
  output logic [NUM_CH-1:0] cs_n,
  output logic [3:0]        sel_ws,
  output logic              sel_aa,
  output logic [1:0]        sel_ps,
  output logic              sel_bem,
  output logic              sel_bstr,
  output logic              sel_bstw
);

  localparam int unsigned MASK_OFS = 4;
  localparam int unsigned CTRL_OFS = 10;

  logic [CMP_W-1:0]        addr_hi;
  logic [NUM_CH-1:0]       hit_vec;
  logic [NUM_CH-1:0]       valid_vec;
  chan_attr_t [NUM_CH-1:0] attr_vec;
  logic [DATA_W-1:0]       rd_part [NUM_CH];
  chan_attr_t              attr_out;
  logic                    unused_addr;

  assign addr_hi     = acc_addr[ADDR_W-1 -: CMP_W];
  assign unused_addr = ^acc_addr[ADDR_W-CMP_W-1:0];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned BOFS = MAP_ORG + c * MAP_STEP;
      localparam int unsigned MOFS = BOFS + MASK_OFS;
      localparam int unsigned COFS = BOFS + CTRL_OFS;

      logic                   at_base, at_mask, at_ctrl;
      logic [CMP_W-1:0]       base_w, amask_w;
      logic [NUM_CLASSES-1:0] tmask_w;
      logic                   amode_w;
      logic [DATA_W-1:0]      rb_base, rb_mask, rb_ctrl;

      assign at_base = (reg_addr == REG_AW'(BOFS));
      assign at_mask = (reg_addr == REG_AW'(MOFS));
      assign at_ctrl = (reg_addr == REG_AW'(COFS));

      csel_chan_regs #(
        .IS_BOOT (c == 0),
        .CMP_W   (CMP_W),
        .DATA_W  (DATA_W)
      ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .boot_ps (boot_ps),
        .wr_base (reg_we & at_base),
        .wr_mask (reg_we & at_mask),
        .wr_ctrl (reg_we & at_ctrl),
        .wdata   (reg_wdata),
        .base_o  (base_w),
        .amask_o (amask_w),
        .tmask_o (tmask_w),
        .amode_o (amode_w),
        .valid_o (valid_vec[c]),
        .attr_o  (attr_vec[c]),
        .rd_base (rb_base),
        .rd_mask (rb_mask),
        .rd_ctrl (rb_ctrl)
      );

      csel_match #(
        .CMP_W (CMP_W)
      ) u_match (
        .addr_hi    (addr_hi),
        .acc_type   (acc_type),
        .acc_dma    (acc_dma),
        .base       (base_w),
        .amask      (amask_w),
        .tmask      (tmask_w),
        .amode      (amode_w),
        .valid      (valid_vec[c]),
        .global_sel ((c == 0) && !valid_vec[c]),
        .hit        (hit_vec[c])
      );

      assign rd_part[c] = ({DATA_W{at_base}} & rb_base)
                        | ({DATA_W{at_mask}} & rb_mask)
                        | ({DATA_W{at_ctrl}} & rb_ctrl);

      if (c == 0) begin : g_boot_chk
        // R5
        boot_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
          ($past(rst_n) && !$past(valid_vec[c])) |-> !cs_n[c]);
      end else begin : g_valid_chk
        // R4
        valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !$past(valid_vec[c]) |-> cs_n[c]);
      end
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) reg_rdata = reg_rdata | rd_part[c];
  end

  csel_select #(
    .NUM_CH (NUM_CH)
  ) u_select (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit_vec),
    .attrs  (attr_vec),
    .cs_n   (cs_n),
    .attr_q (attr_out)
  );

  assign sel_ws   = attr_out.ws;
  assign sel_aa   = attr_out.aa;
  assign sel_ps   = attr_out.ps;
  assign sel_bem  = attr_out.bem;
  assign sel_bstr = attr_out.bstr;
  assign sel_bstw = attr_out.bstw;

endmodule

// File: tb/tb_csel_decoder.sv
`timescale 1ns/1ps
module tb_csel_decoder;

  logic        clk;
  logic        rst_n;
  logic [1:0]  boot_ps;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] acc_addr;
  logic [2:0]  acc_type;
  logic        acc_dma;
  logic [6:0]  cs_n;
  logic [3:0]  sel_ws;
  logic        sel_aa;
  logic [1:0]  sel_ps;
  logic        sel_bem;
  logic        sel_bstr;
  logic        sel_bstw;

  int checks;
  int errors;
  bit done;

  csel_decoder dut (
    .clk(clk), .rst_n(rst_n), .boot_ps(boot_ps),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_addr(acc_addr), .acc_type(acc_type),
    .acc_dma(acc_dma), .cs_n(cs_n), .sel_ws(sel_ws), .sel_aa(sel_aa),
    .sel_ps(sel_ps), .sel_bem(sel_bem), .sel_bstr(sel_bstr),
    .sel_bstw(sel_bstw)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [9:0] attr_now();
    return {sel_bstw, sel_bstr, sel_bem, sel_ps, sel_aa, sel_ws};
  endfunction

  function automatic logic [7:0] ofs_base(int n); return 8'(8'h80 + 12 * n); endfunction
  function automatic logic [7:0] ofs_mask(int n); return 8'(8'h84 + 12 * n); endfunction
  function automatic logic [7:0] ofs_ctrl(int n); return 8'(8'h8A + 12 * n); endfunction

  task automatic check_out(input logic [6:0] exp_cs, input logic [9:0] exp_at,
                           input string req);
    checks++;
    if (cs_n !== exp_cs || attr_now() !== exp_at) begin
      errors++;
      $display("FAIL %s: cs_n=%b attr=%h expected cs_n=%b attr=%h",
               req, cs_n, attr_now(), exp_cs, exp_at);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata@%h=%h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] t, input logic d);
    @(negedge clk);
    acc_addr = a; acc_type = t; acc_dma = d;
    @(posedge clk);
    #1;
  endtask

  // R10, R6: reset state and boot control word
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check_out(7'h7F, 10'h000, "R10 reset");
    rst_n = 1'b1;
    rd_check(ofs_ctrl(0), 32'h0000_005F, "R6 boot ctrl");
    rd_check(ofs_mask(3) + 8'h01, 32'h0, "R9 unmapped");
  endtask

  // R5: region 0 claims every access before it is valid
  task automatic t_global();
    for (int t = 0; t < 6; t++) begin
      for (int d = 0; d < 2; d++) begin
        access(32'h1357_0000 + 32'(t) * 32'h1111_0000, 3'(t), 1'(d));
        check_out(7'b111_1110, 10'h05F, "R5 global");
      end
    end
  endtask

  // R8, R9, R1, R10, R4: program regions 0 and 1
  task automatic t_basic();
    wr(ofs_ctrl(0), 32'h0000_0012);
    wr(ofs_base(0), 32'h0000_0000);
    wr(ofs_mask(0), 32'h0000_0001);
    access(32'h0000_1234, 3'd1, 1'b0);
    check_out(7'b111_1110, 10'h012, "R8 ch0 attrs");
    access(32'h5000_0000, 3'd1, 1'b0);
    check_out(7'h7F, 10'h000, "R8 no select");
    wr(ofs_base(1), 32'h1000_0000);
    wr(ofs_ctrl(1), 32'h0000_02A3);
    wr(ofs_mask(1), 32'h00FF_0000);
    access(32'h1000_0000, 3'd2, 1'b0);
    check_out(7'h7F, 10'h000, "R4 invalid ch1");
    wr(ofs_mask(1), 32'h00FF_0001);
    access(32'h1000_0000, 3'd2, 1'b0);
    check_out(7'b111_1101, 10'h2A3, "R8 ch1 attrs");
    access(32'h10FF_FFFC, 3'd4, 1'b0);
    check_out(7'b111_1101, 10'h2A3, "R1 dont-care bits");
    // R10: result still held just before the next edge
    @(negedge clk);
    acc_addr = 32'h1100_0000;
    #1;
    check_out(7'b111_1101, 10'h2A3, "R10 hold before edge");
    @(posedge clk);
    #1;
    check_out(7'h7F, 10'h000, "R1 compared bit miss");
    access(32'h0010_0000, 3'd0, 1'b0);
    check_out(7'h7F, 10'h000, "R1 ch0 window miss");
    rd_check(ofs_mask(1), 32'h00FF_0001, "R9 mask readback");
    rd_check(ofs_base(1), 32'h1000_0000, "R9 base readback");
    rd_check(ofs_ctrl(1), 32'h0000_02A3, "R9 ctrl readback");
  endtask

  // R2, R3, R4, R1: class x DMA x valid x window sweep on region 2
  task automatic t_sweep();
    wr(ofs_base(2), 32'h2000_0000);
    wr(ofs_ctrl(2), 32'h0000_0001);
    for (int mb = 0; mb < 5; mb++) begin
      for (int am = 0; am < 2; am++) begin
        for (int v = 0; v < 2; v++) begin
          wr(ofs_mask(2), (32'(am) << 8) | (32'h1 << (mb + 1)) | 32'(v));
          for (int t = 0; t < 5; t++) begin
            for (int d = 0; d < 2; d++) begin
              for (int h = 0; h < 2; h++) begin
                bit blocked;
                bit sel;
                blocked = (mb == t) && !(d == 1 && am == 0 && t != 0);
                sel = (v == 1) && (h == 1) && !blocked;
                access(h == 1 ? 32'h2000_0040 : 32'h2100_0000, 3'(t), 1'(d));
                check_out(sel ? 7'b111_1011 : 7'h7F, sel ? 10'h001 : 10'h000,
                          "R2 R3 class/dma sweep");
              end
            end
          end
        end
      end
    end
    wr(ofs_mask(2), 32'h0000_0001);
    access(32'h2000_0000, 3'd5, 1'b0);
    check_out(7'h7F, 10'h000, "R2 reserved class");
    access(32'h2000_0000, 3'd3, 1'b1);
    check_out(7'b111_1011, 10'h001, "R2 unblocked class");
  endtask

  // R7: overlapping regions
  task automatic t_priority();
    wr(ofs_base(3), 32'h3000_0000);
    wr(ofs_ctrl(3), 32'h0000_000A);
    wr(ofs_mask(3), 32'h0000_0001);
    wr(ofs_base(4), 32'h3000_0000);
    wr(ofs_ctrl(4), 32'h0000_000C);
    wr(ofs_mask(4), 32'h000F_0001);
    access(32'h3000_0000, 3'd2, 1'b0);
    check_out(7'b111_0111, 10'h00A, "R7 lowest wins");
    access(32'h3005_0000, 3'd2, 1'b0);
    check_out(7'b110_1111, 10'h00C, "R7 only ch4");
    wr(ofs_mask(3), 32'h0000_0000);
    access(32'h3000_0000, 3'd2, 1'b0);
    check_out(7'b110_1111, 10'h00C, "R7 R4 ch3 invalid");
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; boot_ps = 2'b10;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    acc_addr = '0; acc_type = '0; acc_dma = 1'b0;
    t_reset();
    t_global();
    t_basic();
    t_sweep();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule